// File: doc/BRIEF.md
# Peripheral Address Router

This block sits between a processor's byte-wide load/store port and a set of peripheral regions. Each region is described at build time by a base address and a length. On each request the block finds which region owns the address. It then raises that region's select strobe and hands the region the address relative to its base, together with a shared write enable and the write data. On a read it returns the selected region's data in the same cycle.

Regions are tested in index order and the lowest index that claims the address wins, so windows may overlap on purpose. An address that no region owns is absorbed rather than faulted. A read of such an address returns zero, and a write to it touches nothing. In both cases a one-cycle flag reports the stray access on the cycle after the request.

The request side is a plain valid-qualified interface with no back-pressure. Every cycle with `req_valid` high is one complete access, and no ready signal exists because no region can stall. Wait states, bursts and widths other than 8 bits are outside this block.

Top module: `periph_addr_router`

## Requirements
- R1: Region i claims address A exactly when A >= base_i and A - base_i < length_i. A region of length zero claims nothing. During a valid request, bit i of `reg_sel` is high only for the region that wins A.
- R2: `reg_offset` carries A minus the winning region's base. It is 0 when no region is selected.
- R3: When more than one region claims A, the region with the lowest index wins, and at most one `reg_sel` bit is ever high.
- R4: A valid read of an address no region claims returns `req_rdata` = 0x00.
- R5: A valid write to an unclaimed address raises no `reg_sel` bit and leaves `reg_we` low, so no region sees it.
- R6: `unmapped_access` is high for exactly the one cycle following a valid request that no region claimed, and low after every other cycle.
- R7: During a valid read that a region claims, `req_rdata` equals that region's byte of `reg_rdata` (region i at bits [8i+7:8i]) in the same cycle. With no valid request, or during a write, `req_rdata` is 0x00 and `reg_sel` is 0.
- R8: `reg_we` is high only during a valid write that a region claims. While it is high, `reg_wdata` equals `req_wdata`.
- R9: The default map has four regions in priority order: region 0 at 0x0000 with 64 bytes (core registers), region 1 at 0x0050 with 7 bytes (clock control), region 2 at 0x08A0 with 8 bytes (serial port), and region 3 at 0x2000 with 8192 bytes (data RAM).
- R10: While reset is held and on the first cycle after it, `unmapped_access` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the unmapped-access flag |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Absolute byte address |
| req_wdata | input | DATA_W | Write byte |
| req_rdata | output | DATA_W | Read byte returned to the requester |
| unmapped_access | output | 1 | Pulse: the previous cycle's request hit no region |
| reg_sel | output | NUM_REGIONS | One select strobe per region |
| reg_we | output | 1 | Shared write enable for the selected region |
| reg_offset | output | ADDR_W | Address relative to the selected region's base |
| reg_wdata | output | DATA_W | Write byte forwarded to the selected region |
| reg_rdata | input | NUM_REGIONS*DATA_W | Read bytes from all regions, region i at [8i+7:8i] |

## Verification
The hardest case to reach from the ports is a true priority conflict, because the default map has no overlapping windows. A second instance with a deliberately layered map covers it. In that map one window lies fully inside a higher-priority window, so the shadowed region must never be selected. The hard case also includes the one-byte edges on both sides of every window, where the claim comparison can be off by one. Directed accesses cover each first byte, each last byte and each first byte past a window. The random phase biases half of its addresses to within two bytes of a window edge or into the layered zone. The rest of the random addresses are spread over the full 64 KB space.

// File: rtl/par_pkg.sv
package par_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/par_region_cmp.sv
// Claim test for one address window plus its relative offset.
module par_region_cmp #(
  parameter int              ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = '0,
  parameter logic [ADDR_W:0]   SIZE = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [ADDR_W-1:0] offset
);
  logic [ADDR_W:0] diff;

  always_comb begin
    diff   = {1'b0, addr} - {1'b0, BASE};
    hit    = (addr >= BASE) && (diff < SIZE);
    offset = diff[ADDR_W-1:0];
  end
endmodule

// File: rtl/par_first_win.sv
// Lowest index among the claiming windows wins.
module par_first_win #(
  parameter int N = 4
) (
  input  logic [N-1:0] hits,
  output logic [N-1:0] grant,
  output logic         any
);
  logic found;

  always_comb begin
    grant = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (hits[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
    any = found;
  end
endmodule

// File: rtl/par_andor_mux.sv
// One-hot AND-OR selector, forced to zero when not enabled.
module par_andor_mux #(
  parameter int N = 4,
  parameter int W = 8
) (
  input  logic [N-1:0]   grant,
  input  logic           en,
  input  logic [N*W-1:0] bus,
  output logic [W-1:0]   dout
);
  always_comb begin
    dout = '0;
    for (int i = 0; i < N; i++) begin
      dout = dout | (bus[i*W +: W] & {W{grant[i] & en}});
    end
  end
endmodule

// File: rtl/periph_addr_router.sv
module periph_addr_router
  import par_pkg::*;
#(
  parameter int NUM_REGIONS = 4,
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter logic [NUM_REGIONS*ADDR_W-1:0] REGION_BASE =
    {16'h2000, 16'h08A0, 16'h0050, 16'h0000},
  parameter logic [NUM_REGIONS*(ADDR_W+1)-1:0] REGION_SIZE =
    {17'h02000, 17'h00008, 17'h00007, 17'h00040}
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic                          req_write,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [DATA_W-1:0]             req_wdata,
  output logic [DATA_W-1:0]             req_rdata,
  output logic                          unmapped_access,
  output logic [NUM_REGIONS-1:0]        reg_sel,
  output logic                          reg_we,
  output logic [ADDR_W-1:0]             reg_offset,
  output logic [DATA_W-1:0]             reg_wdata,
  input  logic [NUM_REGIONS*DATA_W-1:0] reg_rdata
);
  localparam int SZ_W = ADDR_W + 1;

  acc_kind_e                    kind;
  logic [NUM_REGIONS-1:0]       hit;
  logic [NUM_REGIONS-1:0]       grant;
  logic                         any_hit;
  logic [NUM_REGIONS*ADDR_W-1:0] ofs_bus;
  logic                         unm_q;

  always_comb begin
    if (!req_valid)     kind = ACC_IDLE;
    else if (req_write) kind = ACC_WRITE;
    else                kind = ACC_READ;
  end

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_win
    par_region_cmp #(
      .ADDR_W (ADDR_W),
      .BASE   (REGION_BASE[g*ADDR_W +: ADDR_W]),
      .SIZE   (REGION_SIZE[g*SZ_W +: SZ_W])
    ) u_cmp (
      .addr   (req_addr),
      .hit    (hit[g]),
      .offset (ofs_bus[g*ADDR_W +: ADDR_W])
    );
  end

  par_first_win #(.N(NUM_REGIONS)) u_win (
    .hits  (hit),
    .grant (grant),
    .any   (any_hit)
  );

  par_andor_mux #(.N(NUM_REGIONS), .W(ADDR_W)) u_ofs_mux (
    .grant (grant),
    .en    (kind != ACC_IDLE),
    .bus   (ofs_bus),
    .dout  (reg_offset)
  );

  par_andor_mux #(.N(NUM_REGIONS), .W(DATA_W)) u_rd_mux (
    .grant (grant),
    .en    (kind == ACC_READ),
    .bus   (reg_rdata),
    .dout  (req_rdata)
  );

  always_comb begin
    reg_sel   = (kind != ACC_IDLE) ? grant : '0;
    reg_we    = (kind == ACC_WRITE) && any_hit;
    reg_wdata = reg_we ? req_wdata : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) unm_q <= 1'b0;
    else        unm_q <= (kind != ACC_IDLE) && !any_hit;
  end

  assign unmapped_access = unm_q;
endmodule

// File: rtl/par_router_chk.sv
module par_router_chk #(
  parameter int NUM_REGIONS = 4,
  parameter int DATA_W      = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_write,
  input logic [NUM_REGIONS-1:0] reg_sel,
  input logic                   reg_we,
  input logic [DATA_W-1:0]      req_rdata,
  input logic                   unmapped_access
);
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reg_sel)); // R3

  AST_WE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (req_valid && req_write && (reg_sel != '0))); // R8

  AST_STRAY_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && reg_sel == '0) |-> !reg_we); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (reg_sel == '0 && req_rdata == '0 && !reg_we)); // R7

  AST_STRAY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && reg_sel == '0) |-> (req_rdata == '0)); // R4

  AST_UNMAPPED_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && reg_sel == '0) |=> unmapped_access); // R6

  AST_UNMAPPED_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && reg_sel != '0) |=> !unmapped_access); // R6

  AST_UNMAPPED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !unmapped_access); // R6
endmodule

bind periph_addr_router par_router_chk #(
  .NUM_REGIONS (NUM_REGIONS),
  .DATA_W      (DATA_W)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .req_valid       (req_valid),
  .req_write       (req_write),
  .reg_sel         (reg_sel),
  .reg_we          (reg_we),
  .req_rdata       (req_rdata),
  .unmapped_access (unmapped_access)
);

// File: tb/periph_addr_router_test.sv
module periph_addr_router_test;
  localparam int CLK_P = 10;

  // Default map (R9) and a layered map for priority (R3)
  localparam int BASE_D[4] = '{32'h0000, 32'h0050, 32'h08A0, 32'h2000};
  localparam int SIZE_D[4] = '{64, 7, 8, 8192};
  localparam int BASE_O[3] = '{32'h0010, 32'h0000, 32'h0018};
  localparam int SIZE_O[3] = '{16, 64, 4};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic [31:0] rd_d = '0;
  logic [23:0] rd_o = '0;

  logic [7:0]  rdata_d, wdata_d, rdata_o, wdata_o;
  logic        unm_d, unm_o, we_d, we_o;
  logic [3:0]  sel_d;
  logic [2:0]  sel_o;
  logic [15:0] ofs_d, ofs_o;

  int total = 0, bad = 0;
  bit done = 0;
  bit exp_unm_d = 0, exp_unm_o = 0;

  always #(CLK_P/2) clk = ~clk;

  periph_addr_router uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_rdata(rdata_d),
    .unmapped_access(unm_d), .reg_sel(sel_d), .reg_we(we_d),
    .reg_offset(ofs_d), .reg_wdata(wdata_d), .reg_rdata(rd_d)
  );

  periph_addr_router #(
    .NUM_REGIONS (3),
    .REGION_BASE ({16'h0018, 16'h0000, 16'h0010}),
    .REGION_SIZE ({17'd4, 17'd64, 17'd16})
  ) uut_ovl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_rdata(rdata_o),
    .unmapped_access(unm_o), .reg_sel(sel_o), .reg_we(we_o),
    .reg_offset(ofs_o), .reg_wdata(wdata_o), .reg_rdata(rd_o)
  );

  function automatic bit claims(input int a, input int b, input int s);
    return (a >= b) && ((a - b) < s);
  endfunction

  function automatic int win_d(input logic [15:0] a);
    for (int i = 0; i < 4; i++) if (claims(int'(a), BASE_D[i], SIZE_D[i])) return i;
    return -1;
  endfunction

  function automatic int win_o(input logic [15:0] a);
    for (int i = 0; i < 3; i++) if (claims(int'(a), BASE_O[i], SIZE_O[i])) return i;
    return -1;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic access(input bit v, input bit w, input logic [15:0] a,
                        input logic [7:0] d, input string tag);
    int wd, wo;
    logic [31:0] e_sel, e_ofs, e_rd;
    @(negedge clk);
    chk("R6", "unmapped flag (default map)", 32'(unm_d), 32'(exp_unm_d));
    chk("R6", "unmapped flag (layered map)", 32'(unm_o), 32'(exp_unm_o));
    req_valid = v; req_write = w; req_addr = a; req_wdata = d;
    rd_d = $urandom; rd_o = 24'($urandom);
    #1;
    wd = v ? win_d(a) : -1;
    wo = v ? win_o(a) : -1;
    // default map
    e_sel = (wd >= 0) ? (32'd1 << wd) : 32'd0;
    e_ofs = (wd >= 0) ? 32'(int'(a) - BASE_D[wd]) : 32'd0;
    e_rd  = (wd >= 0 && !w) ? 32'(rd_d[wd*8 +: 8]) : 32'd0;
    chk(tag, $sformatf("sel addr=%h", a), 32'(sel_d), e_sel);
    chk("R2", $sformatf("offset addr=%h", a), 32'(ofs_d), e_ofs);
    chk((wd < 0 && v && !w) ? "R4" : "R7", $sformatf("rdata addr=%h", a),
        32'(rdata_d), e_rd);
    chk((wd < 0) ? "R5" : "R8", $sformatf("we addr=%h", a),
        32'(we_d), 32'(v && w && wd >= 0));
    if (v && w && wd >= 0) chk("R8", "wdata forward", 32'(wdata_d), 32'(d));
    // layered map
    e_sel = (wo >= 0) ? (32'd1 << wo) : 32'd0;
    e_ofs = (wo >= 0) ? 32'(int'(a) - BASE_O[wo]) : 32'd0;
    e_rd  = (wo >= 0 && !w) ? 32'(rd_o[wo*8 +: 8]) : 32'd0;
    chk("R3", $sformatf("layered sel addr=%h", a), 32'(sel_o), e_sel);
    chk("R2", $sformatf("layered offset addr=%h", a), 32'(ofs_o), e_ofs);
    chk("R7", $sformatf("layered rdata addr=%h", a), 32'(rdata_o), e_rd);
    exp_unm_d = v && (wd < 0);
    exp_unm_o = v && (wo < 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] a;
    int k, r;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk("R10", "flag during reset", 32'(unm_d), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "flag after reset", 32'(unm_d), 32'd0);
    chk("R7", "idle sel after reset", 32'(sel_d), 32'd0);

    // R9 / R1 window edges of the default map
    access(1, 0, 16'h0000, 8'h00, "R9");
    access(1, 0, 16'h003F, 8'h00, "R1");
    access(1, 0, 16'h0040, 8'h00, "R1");
    access(1, 0, 16'h004F, 8'h00, "R1");
    access(1, 0, 16'h0050, 8'h00, "R9");
    access(1, 1, 16'h0056, 8'h5A, "R1");
    access(1, 0, 16'h0057, 8'h00, "R1");
    access(1, 1, 16'h089F, 8'hC3, "R1");
    access(1, 0, 16'h08A0, 8'h00, "R9");
    access(1, 1, 16'h08A7, 8'h7E, "R1");
    access(1, 0, 16'h08A8, 8'h00, "R1");
    access(1, 0, 16'h1FFF, 8'h00, "R1");
    access(1, 1, 16'h2000, 8'h11, "R9");
    access(1, 0, 16'h3FFF, 8'h00, "R1");
    access(1, 1, 16'h4000, 8'hEE, "R1");
    access(1, 0, 16'hFFFF, 8'h00, "R1");
    // idle and back-to-back stray accesses
    access(0, 1, 16'h0000, 8'hFF, "R7");
    access(1, 1, 16'h0045, 8'h99, "R5");
    access(1, 0, 16'h0045, 8'h00, "R4");
    access(0, 0, 16'h2000, 8'h00, "R7");
    // layered-map priority corners
    access(1, 0, 16'h0018, 8'h00, "R3");
    access(1, 0, 16'h001B, 8'h00, "R3");
    access(1, 0, 16'h000F, 8'h00, "R3");
    access(1, 0, 16'h001F, 8'h00, "R3");
    access(1, 0, 16'h0020, 8'h00, "R3");

    for (int n = 0; n < 3000; n++) begin
      r = int'($urandom % 4);
      if (r == 0) begin
        k = int'($urandom % 4);
        a = 16'((($urandom % 2) ? BASE_D[k] + SIZE_D[k] : BASE_D[k])
                + int'($urandom % 5) - 2);
      end else if (r == 1) begin
        a = 16'($urandom % 16'h0060);
      end else begin
        a = 16'($urandom);
      end
      access(($urandom % 8) != 0, $urandom % 2, a, 8'($urandom), "R1");
    end
    access(0, 0, 16'h0000, 8'h00, "R7");
    @(negedge clk);
    chk("R6", "final flag", 32'(unm_d), 32'(exp_unm_d));
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule